// File: doc/BRIEF.md
# Hardware Reset Sequencer

This block returns a serial memory device's internal state to standby, either at power-up or when its active-low reset pin is driven low. A recognized reset stops any embedded operation, and the device's outputs go to high impedance. When the reset is released, the block steps through a fixed initialization. It first strobes the register file so that only the volatile configuration and status bits return to their defaults, and it clears the bank address register in the same cycle. It then writes all-ones into every program buffer location, one location per clock. Next it holds a configuration-reload strobe for a set number of cycles. Only after all of that does it raise `ready` to the command interface.

The pin is brought into the clock domain through two flops. A low level must last `LOW_MIN` clocks before it is treated as a reset, so shorter glitches are filtered out. If a board leaves the pin unconnected, it must be tied high outside this block. A qualified reset during any step of the initialization sends the sequencer back to its hold state. After release, the sequence starts again from the first step. The power-on pulse runs the same sequence as the pin.

The states are ST_HOLD, ST_RESTORE, ST_FILL, ST_RELOAD and ST_READY. The transitions are:
- ST_HOLD to ST_RESTORE, once the synchronized pin is high.
- ST_RESTORE to ST_FILL, unconditionally.
- ST_FILL to ST_RELOAD, at the last buffer address.
- ST_RELOAD to ST_READY, at the last reload cycle.
- Any state other than ST_HOLD to ST_HOLD, on a qualified reset.
- Any state to ST_HOLD asynchronously, while `por_i` is high.

Top module: `hw_reset_seq`

## Requirements
- R1: While `por_i` is high, and while a recognized reset is still held low, `out_hiz` = 1, `op_abort` = 1 and `ready` = 0.
- R2: A low on `rst_pin_n` lasting fewer than `LOW_MIN` clocks has no effect, so `ready` stays 1 and `out_hiz` stays 0. A low lasting `LOW_MIN` clocks is recognized as a reset.
- R3: After release, `vol_restore` and `bank_clear` pulse high together for exactly one cycle, before the first buffer write.
- R4: The buffer fill issues exactly `BUF_DEPTH` writes (`buf_we` = 1) on consecutive cycles. The addresses run 0, 1, … `BUF_DEPTH`-1, and `buf_wdata` is all ones on each write.
- R5: After the last buffer write, `cfg_reload` is high for exactly `CFG_CYCLES` consecutive cycles.
- R6: Count the first rising clock edge at which the synchronizer samples a released (high) pin or a low `por_i` as edge 1. `ready` is high after edge `BUF_DEPTH`+`CFG_CYCLES`+4 and is low before it.
- R7: `out_hiz` is 0 only when `ready` is 1.
- R8: A qualified reset during the initialization sends the block to hold. After release, the whole sequence runs again from the restore step, and the fill restarts at address 0.
- R9: `op_abort` is high only in the hold state, and it is low during the restore, fill and reload steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous assert |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous to clk |
| op_abort | output | 1 | Terminates an embedded operation in progress |
| out_hiz | output | 1 | Forces device outputs to high impedance |
| vol_restore | output | 1 | Strobe: reload volatile register bits to defaults |
| bank_clear | output | 1 | Strobe: clear bank address register |
| buf_we | output | 1 | Program buffer write enable |
| buf_addr | output | $clog2(BUF_DEPTH) | Program buffer write address |
| buf_wdata | output | BUF_DW | Program buffer write data (all ones) |
| cfg_reload | output | 1 | Configuration reload in progress |
| ready | output | 1 | Device in standby, accepting commands |

## Verification
A stuck or wrongly decoded state shows up at once as a wrong combination of `out_hiz`, `op_abort`, `ready` and the strobes, within a cycle of the faulty transition. A miscounting fill or reload counter cannot stay hidden. It changes the number or order of buffer writes, and it moves the cycle at which `ready` rises, which the bench measures exactly against `BUF_DEPTH`+`CFG_CYCLES`+4. A filter that is off by one either lets a `LOW_MIN`-1 glitch drop `ready`, or misses a `LOW_MIN` low. A restart that fails to clear the counters gives a short fill after the re-release.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
    typedef enum logic [2:0] {
        ST_HOLD,
        ST_RESTORE,
        ST_FILL,
        ST_RELOAD,
        ST_READY
    } seq_state_t;
endpackage

// File: rtl/hrs_pin_filter.sv
module hrs_pin_filter #(
    parameter int LOW_MIN = 4
) (
    input  logic clk,
    input  logic por,
    input  logic pin_n,
    output logic pin_high,
    output logic qual
);
    localparam int CW = $clog2(LOW_MIN + 1);

    logic          s1_q;
    logic          s2_q;
    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            s1_q      <= 1'b0;
            s2_q      <= 1'b0;
            low_cnt_q <= '0;
        end else begin
            s1_q <= pin_n;
            s2_q <= s1_q;
            if (s2_q) begin
                low_cnt_q <= '0;
            end else if (low_cnt_q != CW'(LOW_MIN)) begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
        end
    end

    assign pin_high = s2_q;
    assign qual     = !s2_q && (low_cnt_q == CW'(LOW_MIN - 1));

    AST_QUAL_SINGLE: assert property (@(posedge clk) disable iff (por)
        qual |=> !qual);  // R2
endmodule

// File: rtl/hrs_step_ctr.sv
module hrs_step_ctr #(
    parameter int LAST = 15,
    localparam int W = (LAST < 1) ? 1 : $clog2(LAST + 1)
) (
    input  logic         clk,
    input  logic         por,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign last = (cnt_q == W'(LAST));

    AST_CTR_BOUND: assert property (@(posedge clk) disable iff (por)
        cnt_q <= W'(LAST));  // R4
endmodule

// File: rtl/hrs_fsm.sv
module hrs_fsm
    import hrs_pkg::*;
(
    input  logic clk,
    input  logic por,
    input  logic pin_high,
    input  logic qual,
    input  logic fill_last,
    input  logic cfg_last,
    output logic fill_clr,
    output logic fill_inc,
    output logic cfg_clr,
    output logic cfg_inc,
    output logic op_abort,
    output logic out_hiz,
    output logic vol_restore,
    output logic bank_clear,
    output logic buf_we,
    output logic cfg_reload,
    output logic ready
);
    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:    if (pin_high)  state_d = ST_RESTORE;
            ST_RESTORE:                state_d = ST_FILL;
            ST_FILL:    if (fill_last) state_d = ST_RELOAD;
            ST_RELOAD:  if (cfg_last)  state_d = ST_READY;
            ST_READY:                  state_d = ST_READY;
            default:                   state_d = ST_HOLD;
        endcase
        if (qual && state_q != ST_HOLD) begin
            state_d = ST_HOLD;
        end
    end

    always_comb begin
        op_abort    = 1'b0;
        out_hiz     = 1'b1;
        vol_restore = 1'b0;
        bank_clear  = 1'b0;
        buf_we      = 1'b0;
        cfg_reload  = 1'b0;
        ready       = 1'b0;
        fill_clr    = 1'b1;
        fill_inc    = 1'b0;
        cfg_clr     = 1'b1;
        cfg_inc     = 1'b0;
        unique case (state_q)
            ST_HOLD:    op_abort = 1'b1;
            ST_RESTORE: begin
                vol_restore = 1'b1;
                bank_clear  = 1'b1;
            end
            ST_FILL: begin
                buf_we   = 1'b1;
                fill_clr = 1'b0;
                fill_inc = 1'b1;
            end
            ST_RELOAD: begin
                cfg_reload = 1'b1;
                cfg_clr    = 1'b0;
                cfg_inc    = 1'b1;
            end
            ST_READY: begin
                out_hiz = 1'b0;
                ready   = 1'b1;
            end
            default:    op_abort = 1'b1;
        endcase
    end

    AST_RESTART_ON_QUAL: assert property (@(posedge clk) disable iff (por)
        qual |=> (state_q == ST_HOLD));  // R8
    AST_READY_AFTER_RELOAD: assert property (@(posedge clk) disable iff (por)
        $rose(ready) |-> $past(cfg_reload));  // R5
    AST_FILL_AFTER_RESTORE: assert property (@(posedge clk) disable iff (por)
        $rose(buf_we) |-> $past(vol_restore) && $past(bank_clear));  // R3
    AST_NO_ABORT_IN_INIT: assert property (@(posedge clk) disable iff (por)
        (buf_we || cfg_reload || vol_restore) |-> !op_abort);  // R9
endmodule

// File: rtl/hw_reset_seq.sv
module hw_reset_seq #(
    parameter int BUF_DEPTH  = 512,
    parameter int BUF_DW     = 8,
    parameter int CFG_CYCLES = 16,
    parameter int LOW_MIN    = 4,
    localparam int AW = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              rst_pin_n,
    output logic              op_abort,
    output logic              out_hiz,
    output logic              vol_restore,
    output logic              bank_clear,
    output logic              buf_we,
    output logic [AW-1:0]     buf_addr,
    output logic [BUF_DW-1:0] buf_wdata,
    output logic              cfg_reload,
    output logic              ready
);
    localparam int CFG_W = (CFG_CYCLES - 1 < 1) ? 1 : $clog2(CFG_CYCLES);

    logic             pin_high;
    logic             qual;
    logic             fill_clr;
    logic             fill_inc;
    logic             fill_last;
    logic             cfg_clr;
    logic             cfg_inc;
    logic             cfg_last;
    logic [CFG_W-1:0] cfg_cnt;

    hrs_pin_filter #(.LOW_MIN(LOW_MIN)) u_filter (
        .clk      (clk),
        .por      (por_i),
        .pin_n    (rst_pin_n),
        .pin_high (pin_high),
        .qual     (qual)
    );

    hrs_step_ctr #(.LAST(BUF_DEPTH - 1)) u_fill_ctr (
        .clk  (clk),
        .por  (por_i),
        .clr  (fill_clr),
        .inc  (fill_inc),
        .cnt  (buf_addr),
        .last (fill_last)
    );

    hrs_step_ctr #(.LAST(CFG_CYCLES - 1)) u_cfg_ctr (
        .clk  (clk),
        .por  (por_i),
        .clr  (cfg_clr),
        .inc  (cfg_inc),
        .cnt  (cfg_cnt),
        .last (cfg_last)
    );

    hrs_fsm u_fsm (
        .clk         (clk),
        .por         (por_i),
        .pin_high    (pin_high),
        .qual        (qual),
        .fill_last   (fill_last),
        .cfg_last    (cfg_last),
        .fill_clr    (fill_clr),
        .fill_inc    (fill_inc),
        .cfg_clr     (cfg_clr),
        .cfg_inc     (cfg_inc),
        .op_abort    (op_abort),
        .out_hiz     (out_hiz),
        .vol_restore (vol_restore),
        .bank_clear  (bank_clear),
        .buf_we      (buf_we),
        .cfg_reload  (cfg_reload),
        .ready       (ready)
    );

    assign buf_wdata = '1;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (por_i)
        (buf_we && $past(buf_we)) |-> (buf_addr == $past(buf_addr) + 1'b1));  // R4
    AST_FILL_FROM_ZERO: assert property (@(posedge clk) disable iff (por_i)
        $rose(buf_we) |-> (buf_addr == '0));  // R4
    AST_HIZ_WHEN_BUSY: assert property (@(posedge clk) disable iff (por_i)
        !ready |-> out_hiz);  // R7
endmodule

// File: tb/hw_reset_seq_tb_top.sv
module hw_reset_seq_tb_top;
    localparam int D  = 512;
    localparam int DW = 8;
    localparam int C  = 16;
    localparam int N  = 4;
    localparam int AW = $clog2(D);
    localparam int T_READY = D + C + 4;

    logic          clk = 1'b0;
    logic          por_i = 1'b1;
    logic          rst_pin_n = 1'b1;
    logic          op_abort, out_hiz, vol_restore, bank_clear, buf_we, cfg_reload, ready;
    logic [AW-1:0] buf_addr;
    logic [DW-1:0] buf_wdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // monitor accumulators (cumulative, only written here)
    int m_writes = 0, m_addr_err = 0, m_data_err = 0, m_vol = 0, m_bank = 0;
    int m_pair_err = 0, m_order_err = 0, m_reload = 0, m_reload_runs = 0;
    int m_exp_addr = 0;
    int m_abort_init = 0, m_hiz_err = 0;
    logic m_prev_we = 1'b0, m_prev_rl = 1'b0, m_restored = 1'b0;

    hw_reset_seq #(.BUF_DEPTH(D), .BUF_DW(DW), .CFG_CYCLES(C), .LOW_MIN(N)) dut_i (
        .clk(clk), .por_i(por_i), .rst_pin_n(rst_pin_n),
        .op_abort(op_abort), .out_hiz(out_hiz), .vol_restore(vol_restore),
        .bank_clear(bank_clear), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .cfg_reload(cfg_reload), .ready(ready)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (!por_i) begin
            if (vol_restore) m_vol++;
            if (bank_clear) m_bank++;
            if (vol_restore != bank_clear) m_pair_err++;
            if (vol_restore) m_restored = 1'b1;
            if (buf_we) begin
                if (!m_restored) m_order_err++;
                if (!m_prev_we) m_exp_addr = 0;
                if (int'(buf_addr) != m_exp_addr) m_addr_err++;
                if (buf_wdata != {DW{1'b1}}) m_data_err++;
                m_exp_addr++;
                m_writes++;
            end
            if (op_abort) m_restored = 1'b0;
            if (cfg_reload) m_reload++;
            if (cfg_reload && !m_prev_rl) m_reload_runs++;
            if (op_abort && (buf_we || cfg_reload || vol_restore)) m_abort_init++;
            if (!out_hiz && !ready) m_hiz_err++;
            m_prev_we = buf_we;
            m_prev_rl = cfg_reload;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // wait until ready, counting rising edges; release was applied at a negedge
    task automatic wait_ready(output int n);
        n = 0;
        while (n < T_READY + 50) begin
            @(negedge clk);
            n++;
            if (ready) break;
        end
    endtask

    // snapshot-based check of one complete initialization
    task automatic check_sequence(input string tag, input int w0, input int v0,
                                  input int b0, input int r0, input int rr0);
        int n;
        wait_ready(n);
        chk(n == T_READY, {tag, " R6 ready edge"}, n, T_READY);
        chk(m_writes - w0 == D, {tag, " R4 write count"}, m_writes - w0, D);
        chk(m_vol - v0 == 1 && m_bank - b0 == 1, {tag, " R3 restore pulses"},
            m_vol - v0, 1);
        chk(m_reload - r0 == C && m_reload_runs - rr0 == 1, {tag, " R5 reload cycles"},
            m_reload - r0, C);
    endtask

    task automatic t_power_up();
        int w0, v0, b0, r0, rr0;
        por_i = 1'b1;
        repeat (5) @(negedge clk);
        chk(out_hiz && op_abort && !ready, "R1 por hold", {out_hiz, op_abort, ready}, 3'b110);
        w0 = m_writes; v0 = m_vol; b0 = m_bank; r0 = m_reload; rr0 = m_reload_runs;
        por_i = 1'b0;
        check_sequence("R8 power-up", w0, v0, b0, r0, rr0);
        chk(!out_hiz && !op_abort, "R7 outputs live when ready", out_hiz, 0);
    endtask

    task automatic t_glitch();
        bit dropped = 1'b0;
        rst_pin_n = 1'b0;
        repeat (N - 1) @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (12) begin
            @(negedge clk);
            if (!ready || out_hiz) dropped = 1'b1;
        end
        chk(!dropped, "R2 short glitch ignored", dropped, 0);
    endtask

    task automatic t_min_pulse();
        int w0, v0, b0, r0, rr0, n;
        bit seen_hold = 1'b0;
        w0 = m_writes; v0 = m_vol; b0 = m_bank; r0 = m_reload; rr0 = m_reload_runs;
        rst_pin_n = 1'b0;
        repeat (N) @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (!ready && out_hiz) seen_hold = 1'b1;
        end
        chk(seen_hold, "R2 min pulse recognized", seen_hold, 1);
        wait_ready(n);
        chk(ready, "R2 sequence completes", ready, 1);
        chk(m_writes - w0 == D, "R4 fill after pin reset", m_writes - w0, D);
        chk(m_vol - v0 == 1, "R3 restore after pin reset", m_vol - v0, 1);
    endtask

    task automatic t_pin_reset();
        int w0, v0, b0, r0, rr0;
        rst_pin_n = 1'b0;
        repeat (N + 6) @(negedge clk);
        chk(out_hiz && op_abort && !ready && !buf_we, "R1 pin hold",
            {out_hiz, op_abort, ready}, 3'b110);
        w0 = m_writes; v0 = m_vol; b0 = m_bank; r0 = m_reload; rr0 = m_reload_runs;
        rst_pin_n = 1'b1;
        check_sequence("pin", w0, v0, b0, r0, rr0);
    endtask

    task automatic t_restart(input int delay, input string tag);
        int w0, v0, b0, r0, rr0;
        rst_pin_n = 1'b0;
        repeat (N + 6) @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (delay) @(negedge clk);
        rst_pin_n = 1'b0;
        repeat (N + 6) @(negedge clk);
        chk(op_abort && out_hiz && !buf_we && !cfg_reload, {tag, " R8 abort to hold"},
            {op_abort, buf_we, cfg_reload}, 3'b100);
        w0 = m_writes; v0 = m_vol; b0 = m_bank; r0 = m_reload; rr0 = m_reload_runs;
        rst_pin_n = 1'b1;
        check_sequence({tag, " R8 restart"}, w0, v0, b0, r0, rr0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_power_up();
        t_glitch();
        t_min_pulse();
        t_pin_reset();
        t_restart(40, "mid-fill");
        t_restart(D + 8, "mid-reload");
        chk(m_addr_err == 0, "R4 address order", m_addr_err, 0);
        chk(m_data_err == 0, "R4 all-ones data", m_data_err, 0);
        chk(m_pair_err == 0, "R3 strobes together", m_pair_err, 0);
        chk(m_order_err == 0, "R3 restore before fill", m_order_err, 0);
        chk(m_abort_init == 0, "R9 abort only in hold", m_abort_init, 0);
        chk(m_hiz_err == 0, "R7 hiz unless ready", m_hiz_err, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule